// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This unit forms the memory address for a single load or store and the updated value of the base register. It takes a base value, an offset chosen from either a zero-extended immediate or a shifted register, and an add/subtract direction. It also takes a choice between pre-indexed and post-indexed addressing and an optional base-update request.

It checks the offset form against the limits of the access class and of one of two rule sets. The older rule set allows a rich shifter and wide immediates for word and unsigned-byte accesses. The newer rule set allows only small left shifts and no negated registers. The result appears at a registered output stage one cycle after a valid request.

A pipeline stage of a load/store unit drives one request per cycle and passes the address to the memory port. The base-update value and its enable go to the register file write port. An encoding that the selected rule set forbids raises a flag and never updates the base.

Top module: `lsag_top`

## Requirements
- R1: While rst_n is low all outputs are zero. The clock edge that samples in_valid high loads ea, wb_val, wb_en and illegal, and sets out_valid. Edges with in_valid low clear out_valid and leave the other outputs unchanged.
- R2: Pre-indexed mode (post_idx=0) gives ea = base ± offset. wb_en is 1 only when wb_req=1 and the encoding is legal. wb_val equals ea when wb_en is 1 and equals the base otherwise.
- R3: Post-indexed mode (post_idx=1) gives ea = base. A legal request always sets wb_en=1, with wb_val = base ± offset, whatever wb_req is.
- R4: With imm_sel=1 the offset is imm_val zero-extended. With imm_sel=0 it is reg_val shifted by shift_amt using shift_kind: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. An amount of 0 means unshifted for every kind.
- R5: sub=1 subtracts the offset from the base; sub=0 adds it.
- R6: acc_class encodes 0 = word, 1 = unsigned byte, 2 = halfword, 3 = signed halfword, 4 = signed byte. Codes 5 to 7 are illegal. Under profile=0, word and unsigned byte accept any 12-bit immediate and any shift kind and amount, in either direction.
- R7: Under profile=0, classes 2, 3 and 4 accept an immediate only below 256 and a register offset only with shift_amt=0. Anything else is illegal.
- R8: Under profile=1, a register offset is legal only with shift_kind=0, shift_amt at most 3 and sub=0, for every class.
- R9: Under profile=1, an immediate offset is legal up to 4095 when added and up to 255 when subtracted, for every class.
- R10: An illegal request sets illegal=1, forces wb_en=0 and wb_val = base, and still presents ea as its mode defines.
- R11: Base 0x4000 with register 0x20 shifted left by 2 gives ea 0x4080. Base 0x200 with immediate 12 gives 0x20C pre-indexed. Post-indexed, the same operands give ea 0x200 and wb_val 0x20C. Immediate 0 pre-indexed without update gives ea = base and wb_en=0.
- R12: Address arithmetic wraps modulo 2^32 for both addition and subtraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| base_val | input | 32 | Base register value |
| imm_sel | input | 1 | 1 selects immediate offset, 0 register offset |
| imm_val | input | 12 | Unsigned immediate offset |
| reg_val | input | 32 | Offset register value |
| shift_kind | input | 2 | Shift type for the register offset |
| shift_amt | input | 5 | Shift amount for the register offset |
| sub | input | 1 | 1 subtracts the offset |
| post_idx | input | 1 | 1 selects post-indexed addressing |
| wb_req | input | 1 | Base update requested (pre-indexed) |
| acc_class | input | 3 | Access size and signedness |
| profile | input | 1 | 0 older rule set, 1 newer rule set |
| out_valid | output | 1 | Result registered this cycle |
| ea | output | 32 | Effective address |
| wb_val | output | 32 | Value for the base register |
| wb_en | output | 1 | Base register write enable |
| illegal | output | 1 | Encoding not allowed by the rules |

## Verification
The only state is the output register, so a wrong captured value appears at ea, wb_val, wb_en or illegal one cycle after the faulty request. A missing clock enable shows as outputs that change during an idle cycle. A fault in the shifter or in the rule check shows up in the first request that uses the affected shift kind, amount, class or profile. Random requests mixed with directed limits, such as immediate 255/256 and shift amounts 3/4, expose such faults within a few hundred cycles.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  typedef enum logic [2:0] {
    AC_WORD  = 3'd0,
    AC_UBYTE = 3'd1,
    AC_HALF  = 3'd2,
    AC_SHALF = 3'd3,
    AC_SBYTE = 3'd4
  } acc_class_e;

  localparam logic PROF_OLD = 1'b0;
  localparam logic PROF_NEW = 1'b1;
endpackage

// File: rtl/lsag_offset_shift.sv
module lsag_offset_shift #(
  parameter int W     = 32,
  parameter int SHW   = 5
) (
  input  logic [W-1:0]   din,
  input  logic [1:0]     kind,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   dout
);
  import lsag_pkg::*;

  logic [W-1:0] stage [0:SHW];

  assign stage[0] = din;

  // One stage per amount bit; stage k moves by 2**k when that bit is set.
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int D = 1 << k;
    logic [W-1:0] moved;
    always_comb begin
      unique case (shift_kind_e'(kind))
        SH_LSL:  moved = stage[k] << D;
        SH_LSR:  moved = stage[k] >> D;
        SH_ASR:  moved = W'($signed(stage[k]) >>> D);
        default: moved = (stage[k] >> D) | (stage[k] << (W - D));
      endcase
    end
    assign stage[k+1] = amt[k] ? moved : stage[k];
  end

  assign dout = stage[SHW];
endmodule

// File: rtl/lsag_rule_check.sv
module lsag_rule_check #(
  parameter int IMM_W     = 12,
  parameter int NARROW_W  = 8,
  parameter int SHW       = 5,
  parameter int NEW_SHMAX = 3
) (
  input  logic             profile,
  input  logic [2:0]       acc_class,
  input  logic             imm_sel,
  input  logic [IMM_W-1:0] imm_val,
  input  logic [1:0]       shift_kind,
  input  logic [SHW-1:0]   shift_amt,
  input  logic             sub,
  output logic             legal
);
  import lsag_pkg::*;

  localparam int HI_W = IMM_W - NARROW_W;

  logic class_ok, narrow, imm_fits_narrow;
  logic old_ok, new_ok;

  always_comb begin
    class_ok        = (acc_class <= 3'(AC_SBYTE));
    narrow          = (acc_class == 3'(AC_HALF)) || (acc_class == 3'(AC_SHALF))
                    || (acc_class == 3'(AC_SBYTE));
    imm_fits_narrow = (imm_val[IMM_W-1 -: HI_W] == '0);

    if (imm_sel) old_ok = !narrow || imm_fits_narrow;
    else         old_ok = !narrow || (shift_amt == '0);

    if (imm_sel) new_ok = !sub || imm_fits_narrow;
    else         new_ok = (shift_kind == 2'(SH_LSL))
                        && (shift_amt <= SHW'(NEW_SHMAX)) && !sub;

    legal = class_ok && ((profile == PROF_NEW) ? new_ok : old_ok);
  end
endmodule

// File: rtl/lsag_addr_calc.sv
module lsag_addr_calc #(
  parameter int W     = 32,
  parameter int IMM_W = 12
) (
  input  logic [W-1:0]     base,
  input  logic             imm_sel,
  input  logic [IMM_W-1:0] imm_val,
  input  logic [W-1:0]     shifted,
  input  logic             sub,
  input  logic             post_idx,
  input  logic             wb_req,
  input  logic             legal,
  output logic [W-1:0]     ea,
  output logic [W-1:0]     wb_val,
  output logic             wb_en
);
  logic [W-1:0] offset, sum;

  always_comb begin
    offset = imm_sel ? W'(imm_val) : shifted;
    sum    = sub ? (base - offset) : (base + offset);
    ea     = post_idx ? base : sum;
    wb_en  = legal && (post_idx || wb_req);
    wb_val = wb_en ? sum : base;
  end
endmodule

// File: rtl/lsag_top.sv
module lsag_top #(
  parameter int W         = 32,
  parameter int IMM_W     = 12,
  parameter int NARROW_W  = 8,
  parameter int SHW       = 5,
  parameter int NEW_SHMAX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     base_val,
  input  logic             imm_sel,
  input  logic [IMM_W-1:0] imm_val,
  input  logic [W-1:0]     reg_val,
  input  logic [1:0]       shift_kind,
  input  logic [SHW-1:0]   shift_amt,
  input  logic             sub,
  input  logic             post_idx,
  input  logic             wb_req,
  input  logic [2:0]       acc_class,
  input  logic             profile,
  output logic             out_valid,
  output logic [W-1:0]     ea,
  output logic [W-1:0]     wb_val,
  output logic             wb_en,
  output logic             illegal
);
  logic [W-1:0] shifted, ea_d, wb_val_d;
  logic         legal_d, wb_en_d;

  lsag_offset_shift #(.W(W), .SHW(SHW)) u_shift (
    .din(reg_val), .kind(shift_kind), .amt(shift_amt), .dout(shifted)
  );

  lsag_rule_check #(.IMM_W(IMM_W), .NARROW_W(NARROW_W), .SHW(SHW),
                    .NEW_SHMAX(NEW_SHMAX)) u_rules (
    .profile(profile), .acc_class(acc_class), .imm_sel(imm_sel),
    .imm_val(imm_val), .shift_kind(shift_kind), .shift_amt(shift_amt),
    .sub(sub), .legal(legal_d)
  );

  lsag_addr_calc #(.W(W), .IMM_W(IMM_W)) u_calc (
    .base(base_val), .imm_sel(imm_sel), .imm_val(imm_val), .shifted(shifted),
    .sub(sub), .post_idx(post_idx), .wb_req(wb_req), .legal(legal_d),
    .ea(ea_d), .wb_val(wb_val_d), .wb_en(wb_en_d)
  );

  // Result register, loaded only on a valid request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ea        <= '0;
      wb_val    <= '0;
      wb_en     <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ea      <= ea_d;
        wb_val  <= wb_val_d;
        wb_en   <= wb_en_d;
        illegal <= !legal_d;
      end
    end
  end

  // Idle cycles keep the result (R1)
  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(ea) && $stable(wb_val) && $stable(wb_en) && $stable(illegal)));

  // Pre-indexed without update leaves the base as is (R2)
  p_pre_keep_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !post_idx && !wb_req) |=> (!wb_en && wb_val == $past(base_val)));

  // Post-indexed uses the unmodified base (R3)
  p_post_ea_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && post_idx) |=> (ea == $past(base_val)));

  // Post-indexed legal requests always update (R3)
  p_post_updates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && post_idx) |=> (illegal || wb_en));

  // Undefined class codes are rejected (R6)
  p_bad_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_class > 3'd4) |=> illegal);

  // Newer rules forbid negated register offsets (R8)
  p_new_no_neg_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && profile && !imm_sel && sub) |=> illegal);

  // Illegal requests never write the base (R10)
  p_illegal_no_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> !wb_en);
endmodule

// File: tb/tb_lsag_top.sv
module tb_lsag_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] base_val, reg_val;
  logic        imm_sel, sub, post_idx, wb_req, profile;
  logic [11:0] imm_val;
  logic [1:0]  shift_kind;
  logic [4:0]  shift_amt;
  logic [2:0]  acc_class;
  logic        out_valid, wb_en, illegal;
  logic [31:0] ea, wb_val;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  lsag_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_val(base_val),
    .imm_sel(imm_sel), .imm_val(imm_val), .reg_val(reg_val),
    .shift_kind(shift_kind), .shift_amt(shift_amt), .sub(sub),
    .post_idx(post_idx), .wb_req(wb_req), .acc_class(acc_class),
    .profile(profile), .out_valid(out_valid), .ea(ea), .wb_val(wb_val),
    .wb_en(wb_en), .illegal(illegal)
  );

  function automatic logic [31:0] ref_shift(input logic [31:0] x,
                                            input logic [1:0] k,
                                            input logic [4:0] a);
    if (a == 0) return x;
    case (k)
      2'd0: return x << a;
      2'd1: return x >> a;
      2'd2: return $unsigned($signed(x) >>> a);
      default: return (x >> a) | (x << (6'd32 - {1'b0, a}));
    endcase
  endfunction

  function automatic logic ref_legal();
    logic narrow;
    if (acc_class > 3'd4) return 1'b0;
    narrow = (acc_class >= 3'd2);
    if (!profile) begin
      if (imm_sel) return !narrow || (imm_val < 12'd256);
      return !narrow || (shift_amt == 0);
    end
    if (imm_sel) return !sub || (imm_val < 12'd256);
    return (shift_kind == 2'd0) && (shift_amt <= 5'd3) && !sub;
  endfunction

  logic [31:0] x_ea, x_wbv;
  logic        x_wben, x_ill;

  task automatic compute_expected();
    logic [31:0] off, sum;
    logic lg;
    off = imm_sel ? {20'd0, imm_val} : ref_shift(reg_val, shift_kind, shift_amt);
    sum = sub ? base_val - off : base_val + off;
    lg  = ref_legal();
    x_ill  = !lg;
    x_ea   = post_idx ? base_val : sum;
    x_wben = lg && (post_idx || wb_req);
    x_wbv  = x_wben ? sum : base_val;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Drive at negedge, compute expected, check at the following negedge.
  task automatic apply(input string req);
    in_valid = 1'b1;
    compute_expected();
    @(negedge clk);
    chk({req, " out_valid"}, {31'd0, out_valid}, 32'd1);
    chk({req, " ea"},        ea,                 x_ea);
    chk({req, " wb_val"},    wb_val,             x_wbv);
    chk({req, " wb_en"},     {31'd0, wb_en},     {31'd0, x_wben});
    chk({req, " illegal"},   {31'd0, illegal},   {31'd0, x_ill});
  endtask

  task automatic set_req(input logic [31:0] b, input logic is_imm, input logic [11:0] im,
                         input logic [31:0] r, input logic [1:0] k, input logic [4:0] a,
                         input logic sb, input logic pst, input logic wr,
                         input logic [2:0] cls, input logic prf);
    base_val = b; imm_sel = is_imm; imm_val = im; reg_val = r; shift_kind = k;
    shift_amt = a; sub = sb; post_idx = pst; wb_req = wr; acc_class = cls; profile = prf;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0;
    set_req(32'hFFFF_FFFF, 1'b1, 12'hFFF, 32'h1, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 reset ea", ea, 32'd0);
    chk("R1 reset wb_val", wb_val, 32'd0);
    chk("R1 reset flags", {30'd0, wb_en, illegal}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 worked examples
    set_req(32'h4000, 1'b0, 12'd0, 32'h20, 2'd0, 5'd2, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
    apply("R11 scaled reg");
    chk("R11 ea 0x4080", ea, 32'h4080);
    set_req(32'h200, 1'b1, 12'd12, 32'h0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
    apply("R11 pre imm");
    chk("R11 ea 0x20C", ea, 32'h20C);
    set_req(32'h200, 1'b1, 12'd12, 32'h0, 2'd0, 5'd0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0);
    apply("R3 post imm");
    chk("R3 post ea", ea, 32'h200);
    chk("R3 post wb_val", wb_val, 32'h20C);
    chk("R3 post wb_en", {31'd0, wb_en}, 32'd1);
    set_req(32'h8000, 1'b1, 12'd0, 32'h0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b1);
    apply("R11 zero offset");
    chk("R11 indirect ea", ea, 32'h8000);

    // R2 pre-indexed with update
    set_req(32'h1000, 1'b1, 12'd4, 32'h0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0);
    apply("R2 pre update");
    chk("R2 wb_val", wb_val, 32'h1004);

    // R1 idle cycle holds outputs
    in_valid = 1'b0;
    base_val = 32'hDEAD_0000;
    @(negedge clk);
    chk("R1 idle out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 idle ea hold", ea, 32'h1004);
    chk("R1 idle wb_val hold", wb_val, 32'h1004);

    // R4 shift kinds on a signed pattern
    set_req(32'h0, 1'b0, 12'd0, 32'h8000_00F1, 2'd1, 5'd4, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
    apply("R4 LSR");
    chk("R4 LSR value", ea, 32'h0800_000F);
    shift_kind = 2'd2; apply("R4 ASR");
    chk("R4 ASR value", ea, 32'hF800_000F);
    shift_kind = 2'd3; apply("R4 ROR");
    chk("R4 ROR value", ea, 32'h1800_000F);
    shift_kind = 2'd3; shift_amt = 5'd0; apply("R4 amount zero");
    chk("R4 unshifted", ea, 32'h8000_00F1);

    // R5 subtract and R12 wrap
    set_req(32'h10, 1'b1, 12'h20, 32'h0, 2'd0, 5'd0, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0);
    apply("R5 R12 sub wrap");
    chk("R12 wrap below zero", ea, 32'hFFFF_FFF0);
    set_req(32'hFFFF_FFFC, 1'b1, 12'h8, 32'h0, 2'd0, 5'd0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0);
    apply("R12 add wrap");
    chk("R12 wrap above max", wb_val, 32'h4);

    // R6 bad class, R7 older narrow limits
    set_req(32'h100, 1'b1, 12'd1, 32'h0, 2'd0, 5'd0, 1'b0, 1'b1, 1'b1, 3'd5, 1'b0);
    apply("R6 class 5");
    chk("R6 illegal", {31'd0, illegal}, 32'd1);
    set_req(32'h100, 1'b1, 12'd255, 32'h0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 3'd3, 1'b0);
    apply("R7 imm 255 ok");
    imm_val = 12'd256; apply("R7 imm 256 rejected");
    chk("R7 256 illegal", {31'd0, illegal}, 32'd1);
    chk("R10 wb_val base", wb_val, 32'h100);
    set_req(32'h100, 1'b0, 12'd0, 32'h4, 2'd0, 5'd1, 1'b0, 1'b1, 1'b0, 3'd4, 1'b0);
    apply("R7 shifted reg rejected");
    chk("R10 post ea kept", ea, 32'h100);
    set_req(32'h100, 1'b1, 12'hFFF, 32'h0, 2'd0, 5'd0, 1'b1, 1'b0, 1'b1, 3'd0, 1'b0);
    apply("R6 word full imm sub");

    // R8 / R9 newer rules
    set_req(32'h100, 1'b0, 12'd0, 32'h2, 2'd0, 5'd3, 1'b0, 1'b0, 1'b1, 3'd2, 1'b1);
    apply("R8 LSL 3 ok");
    shift_amt = 5'd4; apply("R8 LSL 4 rejected");
    chk("R8 illegal", {31'd0, illegal}, 32'd1);
    shift_amt = 5'd1; shift_kind = 2'd1; apply("R8 LSR rejected");
    shift_kind = 2'd0; sub = 1'b1; apply("R8 negated rejected");
    set_req(32'h1000, 1'b1, 12'd4095, 32'h0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 3'd4, 1'b1);
    apply("R9 add 4095 ok");
    sub = 1'b1; imm_val = 12'd255; apply("R9 sub 255 ok");
    imm_val = 12'd256; apply("R9 sub 256 rejected");
    chk("R9 illegal", {31'd0, illegal}, 32'd1);

    // Random mix, R2..R10
    for (int i = 0; i < 600; i++) begin
      base_val   = $urandom;
      imm_sel    = $urandom_range(0, 1);
      imm_val    = ($urandom_range(0, 2) == 0) ? 12'($urandom_range(250, 260)) : 12'($urandom);
      reg_val    = $urandom;
      shift_kind = ($urandom_range(0, 1) == 0) ? 2'd0 : 2'($urandom);
      shift_amt  = ($urandom_range(0, 1) == 0) ? 5'($urandom_range(0, 4)) : 5'($urandom);
      sub        = $urandom_range(0, 1);
      post_idx   = $urandom_range(0, 1);
      wb_req     = $urandom_range(0, 1);
      acc_class  = 3'($urandom_range(0, 5));
      profile    = $urandom_range(0, 1);
      apply("R2-R10 random");
      if ($urandom_range(0, 7) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
        chk("R1 random idle hold", ea, x_ea);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule